// File: doc/BRIEF.md
# Protected Non-Volatile Array Access Controller

This block lets a host reach a small byte-addressed non-volatile array through a handful of byte-wide registers. The host loads a command (mode, length, low address bits), fills a write buffer if needed, then writes the control register with the start bit, direction, buffer-half select and high address bits. Reads copy up to eight bytes of one 8-byte row into the read buffer. Writes run an internal row sequence: the row is loaded, the new bytes are merged, and only when the merged row differs from the stored row is the row erased and then programmed back. Completion is found by polling the busy bit.

Writes into the 64-byte user area are screened by eight region-protect bits. A security register adds global write protection, read protection and counter write protection. All protect bits can only be raised; they fall only at reset. A blocked access leaves the array untouched and raises a sticky error flag. A 32-bit life-span count is held bit-inverted in the array. A counter-mode command decrements it in place, and a mode operation loads it with its maximum. A mode bit freezes the count.

The array is modelled as registers that reset to the erased value 0xFF. Erase and program take fixed cycle counts set by parameters.

Top module: `nvm_guard_ctrl`

## Requirements
- R1: After reset every control, command, protect, security, mode and status register and both buffers read 0, busy is 0, and every array byte holds 0xFF.
- R2: A read (control bit 7 = 1, bit 6 = 0) copies N bytes into the read buffer, where N = 1, 2, 4 or 8 for length code 0..3 in command bits [4:3]. Byte k comes from row (control bits [4:0]) at offset (command bits [2:0] + k) mod 8. It is written to buffer index 8*sel + k, where sel is control bit 5. Busy is high for exactly one cycle.
- R3: A write (control bit 6 = 1, command bit 5 = 0) places write-buffer byte 8*sel + k at row offset (low address + k) mod 8. When the row changes, busy is high for 2 + 64 + 32 = 98 cycles: load, compare, erase and program. The stored row then equals the merged data.
- R4: When the merged row equals the stored row, busy is high for exactly 2 cycles and no erase or program occurs.
- R5: A write to row r < 8 while write-protect register bit r is set does not raise busy. It leaves the array unchanged and sets the error flag (status bit 0). Unprotected rows stay writable.
- R6: Security bit 0 blocks every direct write. Security bit 2 blocks any write that touches counter bytes 0x48..0x4B, as well as decrements and maximum loads. Each blocked access sets the error flag, does not raise busy and leaves the array unchanged.
- R7: With security bit 1 set, a read does not raise busy, leaves the read buffer unchanged and sets the error flag.
- R8: Writes to the write-protect and security registers can only set bits; a 0 written over a 1 has no effect until reset.
- R9: The count is the bitwise inverse of the little-endian word at 0x48..0x4B. A start with command bit 5 = 1 and direction write decrements the count through the full row sequence. When the count is already 0, it sets the error flag and changes nothing.
- R10: Writing 1 to mode bit 1 loads the count with all ones (stored bytes 0x00). While mode bit 0 is set, a decrement is ignored with no busy, no error and no change.
- R11: While busy, register writes other than the error clear are ignored, including a new start.
- R12: The error flag stays set until a write to the status register with bit 0 = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address: 0x00-0x0F read buffer, 0x10-0x1F write buffer, 0x20 control, 0x21 command, 0x22 write protect, 0x23 security, 0x24 mode, 0x25 status |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr (combinational) |

## Verification
Several properties are checked on every cycle: the erase and program phases run their full lengths, the protect and security bits never fall, the error flag holds until it is cleared, a start issued while busy cannot retarget the running operation, and a write that protection blocks never leaves idle. Other behaviours can only be shown by the bench's scenarios, because they depend on array contents read back through the buffers. These are byte placement with wrap-around and buffer-half selection, the skip of unchanged rows seen as a 2-cycle busy, the inverted counter arithmetic, the zero-count and frozen-count cases, and the fact that blocked accesses leave memory and buffers intact.

// File: rtl/nvm_guard_ctrl.sv
module nvm_guard_ctrl #(
  parameter int ERASE_CYC = 64,
  parameter int PROG_CYC  = 32,
  parameter int CNT_ADDR  = 72,
  parameter int USER_ROWS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [5:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata
);
  localparam int NVM_BYTES = 256;
  localparam int PH_W = $clog2(ERASE_CYC > PROG_CYC ? ERASE_CYC : PROG_CYC);
  localparam logic [4:0] CNT_ROW = 5'(CNT_ADDR / 8);
  localparam int CNT_OFF = CNT_ADDR % 8;
  localparam logic [7:0] CNT_LO = 8'(CNT_ADDR);
  localparam logic [7:0] CNT_HI = 8'(CNT_ADDR + 3);
  localparam logic [5:0] A_CTRL = 6'h20, A_CMD = 6'h21, A_WPROT = 6'h22,
                         A_SEC = 6'h23, A_MODE = 6'h24, A_STAT = 6'h25;

  typedef enum logic [2:0] {S_IDLE, S_READ, S_LOAD, S_CMP, S_ERASE, S_PROG} st_t;
  typedef enum logic [1:0] {K_WR, K_DEC, K_MAX} kind_t;

  logic [7:0] mem [NVM_BYTES];
  logic [7:0] rbuf [16];
  logic [7:0] wbuf [16];
  logic [7:0] rowbuf [8];
  logic [7:0] cur [8];
  logic [7:0] merged [8];

  logic [4:0] ahi;
  logic       dir, sel, cmode, stop, err;
  logic [1:0] lcode;
  logic [2:0] alo;
  logic [7:0] wprot;
  logic [2:0] sec;

  st_t        st;
  kind_t      op_kind;
  logic [PH_W-1:0] ph;
  logic [4:0] op_row;
  logic [2:0] op_lo;
  logic       op_sel;
  logic [7:0] op_mask;

  function automatic logic [2:0] woff(input logic [2:0] lo, input int k);
    return lo + k[2:0];
  endfunction

  wire busy = (st != S_IDLE);
  wire start_req = reg_wr && (reg_addr == A_CTRL) && reg_wdata[7] && !busy;
  wire max_req = reg_wr && (reg_addr == A_MODE) && reg_wdata[1] && !busy;
  wire [7:0] lmask = (lcode == 2'd0) ? 8'h01 : (lcode == 2'd1) ? 8'h03 :
                     (lcode == 2'd2) ? 8'h0F : 8'hFF;
  wire [31:0] cnt_val = {mem[CNT_ADDR+3], mem[CNT_ADDR+2], mem[CNT_ADDR+1], mem[CNT_ADDR]};
  wire cnt_zero = (cnt_val == 32'hFFFF_FFFF);

  logic touch_cnt, blk_wr, same;
  logic [31:0] cnt_nv;

  always_comb begin
    touch_cnt = 1'b0;
    for (int k = 0; k < 8; k++)
      if (lmask[k] && ({reg_wdata[4:0], woff(alo, k)} >= CNT_LO) &&
          ({reg_wdata[4:0], woff(alo, k)} <= CNT_HI))
        touch_cnt = 1'b1;
    blk_wr = sec[0] || (sec[2] && touch_cnt) ||
             ((32'(reg_wdata[4:0]) < USER_ROWS) && wprot[reg_wdata[2:0]]);
  end

  always_comb begin
    cnt_nv = (op_kind == K_DEC) ? cnt_val + 32'd1 : 32'd0;
    for (int i = 0; i < 8; i++) begin
      cur[i] = mem[{op_row, i[2:0]}];
      merged[i] = cur[i];
    end
    if (op_kind == K_WR) begin
      for (int k = 0; k < 8; k++)
        if (op_mask[k]) merged[woff(op_lo, k)] = wbuf[{op_sel, k[2:0]}];
    end else begin
      for (int j = 0; j < 4; j++) merged[CNT_OFF + j] = cnt_nv[8*j +: 8];
    end
    same = 1'b1;
    for (int i = 0; i < 8; i++)
      if (rowbuf[i] != cur[i]) same = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NVM_BYTES; i++) mem[i] <= 8'hFF;
      for (int i = 0; i < 16; i++) begin
        rbuf[i] <= 8'h00;
        wbuf[i] <= 8'h00;
      end
      for (int i = 0; i < 8; i++) rowbuf[i] <= 8'h00;
      {ahi, dir, sel, cmode, stop, err, lcode, alo} <= '0;
      wprot <= '0;
      sec <= '0;
      st <= S_IDLE;
      op_kind <= K_WR;
      ph <= '0;
      op_row <= '0;
      op_lo <= '0;
      op_sel <= 1'b0;
      op_mask <= '0;
    end else begin
      if (reg_wr && reg_addr == A_STAT && reg_wdata[0]) err <= 1'b0;
      case (st)
        S_IDLE: begin
          if (reg_wr) begin
            if (reg_addr[5:4] == 2'b01) wbuf[reg_addr[3:0]] <= reg_wdata;
            case (reg_addr)
              A_CTRL:  {dir, sel, ahi} <= reg_wdata[6:0];
              A_CMD:   {cmode, lcode, alo} <= reg_wdata[5:0];
              A_WPROT: wprot <= wprot | reg_wdata;
              A_SEC:   sec <= sec | reg_wdata[2:0];
              A_MODE:  stop <= reg_wdata[0];
              default: ;
            endcase
          end
          if (start_req) begin
            op_sel <= reg_wdata[5];
            op_lo <= alo;
            op_mask <= lmask;
            if (!reg_wdata[6]) begin
              if (sec[1]) err <= 1'b1;
              else begin
                op_row <= reg_wdata[4:0];
                st <= S_READ;
              end
            end else if (cmode) begin
              if (!stop) begin
                if (sec[2] || cnt_zero) err <= 1'b1;
                else begin
                  op_kind <= K_DEC;
                  op_row <= CNT_ROW;
                  st <= S_LOAD;
                end
              end
            end else if (blk_wr) begin
              err <= 1'b1;
            end else begin
              op_kind <= K_WR;
              op_row <= reg_wdata[4:0];
              st <= S_LOAD;
            end
          end else if (max_req) begin
            if (sec[2]) err <= 1'b1;
            else begin
              op_kind <= K_MAX;
              op_row <= CNT_ROW;
              st <= S_LOAD;
            end
          end
        end
        S_READ: begin
          for (int k = 0; k < 8; k++)
            if (op_mask[k]) rbuf[{op_sel, k[2:0]}] <= mem[{op_row, woff(op_lo, k)}];
          st <= S_IDLE;
        end
        S_LOAD: begin
          for (int i = 0; i < 8; i++) rowbuf[i] <= merged[i];
          st <= S_CMP;
        end
        S_CMP: begin
          ph <= '0;
          st <= same ? S_IDLE : S_ERASE;
        end
        S_ERASE: begin
          if (ph == PH_W'(ERASE_CYC - 1)) begin
            for (int i = 0; i < 8; i++) mem[{op_row, i[2:0]}] <= 8'hFF;
            ph <= '0;
            st <= S_PROG;
          end else ph <= ph + 1'b1;
        end
        S_PROG: begin
          if (ph == PH_W'(PROG_CYC - 1)) begin
            for (int i = 0; i < 8; i++) mem[{op_row, i[2:0]}] <= cur[i] & rowbuf[i];
            st <= S_IDLE;
          end else ph <= ph + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    reg_rdata = 8'h00;
    if (reg_addr[5] == 1'b0)
      reg_rdata = reg_addr[4] ? wbuf[reg_addr[3:0]] : rbuf[reg_addr[3:0]];
    else
      case (reg_addr)
        A_CTRL:  reg_rdata = {busy, dir, sel, ahi};
        A_CMD:   reg_rdata = {2'b00, cmode, lcode, alo};
        A_WPROT: reg_rdata = wprot;
        A_SEC:   reg_rdata = {5'b0, sec};
        A_MODE:  reg_rdata = {7'b0, stop};
        A_STAT:  reg_rdata = {busy, 6'b0, err};
        default: reg_rdata = 8'h00;
      endcase
  end

  AST_ERASE_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PROG && $past(st) == S_ERASE) |-> $past(ph) == PH_W'(ERASE_CYC - 1)); // R3
  AST_PROG_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && $past(st) == S_PROG) |-> $past(ph) == PH_W'(PROG_CYC - 1)); // R3
  AST_PROT_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && reg_wdata[6] && !cmode && blk_wr) |=> (st == S_IDLE && err)); // R5
  AST_WPROT_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wprot) & ~wprot) == 8'h00); // R8
  AST_SEC_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sec) & ~sec) == 3'h0); // R8
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr && reg_addr == A_CTRL) |=> op_row == $past(op_row)); // R11
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(err) && !$past(reg_wr && reg_addr == A_STAT && reg_wdata[0])) |-> err); // R12
endmodule

// File: tb/sim_nvm_guard_ctrl.sv
module sim_nvm_guard_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [5:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;

  localparam logic [5:0] A_CTRL = 6'h20, A_CMD = 6'h21, A_WPROT = 6'h22,
                         A_SEC = 6'h23, A_MODE = 6'h24, A_STAT = 6'h25;

  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_q [$];
  logic [5:0] adr_q [$];
  string tag_q [$];
  event smp;

  nvm_guard_ctrl u0 (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
                     .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  always #4 clk = ~clk;

  initial forever begin
    @(smp);
    while (exp_q.size() > 0) begin
      logic [7:0] e;
      logic [5:0] a;
      string t;
      e = exp_q.pop_front();
      a = adr_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if (reg_rdata !== e) begin
        n_fail++;
        $display("FAIL %s: reg %02h got %02h expected %02h", t, a, reg_rdata, e);
      end
    end
  end

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    reg_wdata = d;
    reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic chk(input logic [5:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    reg_addr = a;
    #1;
    exp_q.push_back(e);
    adr_q.push_back(a);
    tag_q.push_back(t);
    -> smp;
    #1;
  endtask

  task automatic cmpi(input int act, input int e, input string t);
    n_chk++;
    if (act != e) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", t, act, e);
    end
  endtask

  task automatic wait_idle(output int cyc);
    int guard;
    cyc = 0;
    guard = 0;
    reg_addr = A_STAT;
    #1;
    while (reg_rdata[7] && guard < 2000) begin
      cyc++;
      guard++;
      @(negedge clk);
      #1;
    end
  endtask

  task automatic setcmd(input logic cm, input logic [1:0] lc, input logic [2:0] lo);
    wr(A_CMD, {2'b00, cm, lc, lo});
  endtask

  task automatic op(input logic d, input logic s, input logic [4:0] hi, output int cyc);
    wr(A_CTRL, {1'b1, d, s, hi});
    wait_idle(cyc);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    int c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    chk(A_STAT, 8'h00, "R1 status");
    chk(A_CTRL, 8'h00, "R1 control");
    chk(A_WPROT, 8'h00, "R1 wprot");
    chk(A_SEC, 8'h00, "R1 security");
    chk(6'h00, 8'h00, "R1 read buffer");
    chk(6'h10, 8'h00, "R1 write buffer");

    setcmd(1'b0, 2'd3, 3'd0);
    op(1'b0, 1'b0, 5'd2, c);
    cmpi(c, 1, "R2 read busy cycles");
    chk(6'h00, 8'hFF, "R1 erased byte 0");
    chk(6'h07, 8'hFF, "R1 erased byte 7");

    for (int i = 0; i < 8; i++) wr(6'(6'h10 + i), 8'(8'hA0 + i));
    op(1'b1, 1'b0, 5'd2, c);
    cmpi(c, 98, "R3 write busy cycles");
    op(1'b0, 1'b0, 5'd2, c);
    for (int i = 0; i < 8; i++) chk(6'(i), 8'(8'hA0 + i), "R3 row content");

    op(1'b1, 1'b0, 5'd2, c);
    cmpi(c, 2, "R4 unchanged row skip");

    for (int i = 0; i < 4; i++) wr(6'(6'h18 + i), 8'(8'h31 + i));
    setcmd(1'b0, 2'd2, 3'd6);
    op(1'b1, 1'b1, 5'd2, c);
    cmpi(c, 98, "R3 wrapped write busy");
    setcmd(1'b0, 2'd3, 3'd0);
    op(1'b0, 1'b1, 5'd2, c);
    chk(6'h08, 8'h33, "R3 wrap byte 0");
    chk(6'h09, 8'h34, "R3 wrap byte 1");
    chk(6'h0A, 8'hA2, "R3 kept byte 2");
    chk(6'h0D, 8'hA5, "R3 kept byte 5");
    chk(6'h0E, 8'h31, "R3 wrap byte 6");
    chk(6'h0F, 8'h32, "R2 upper half byte 7");
    setcmd(1'b0, 2'd1, 3'd7);
    op(1'b0, 1'b0, 5'd2, c);
    chk(6'h00, 8'h32, "R2 read wrap first");
    chk(6'h01, 8'h33, "R2 read wrap second");
    chk(6'h02, 8'hA2, "R2 bytes beyond length untouched");

    wr(6'h10, 8'h55);
    setcmd(1'b0, 2'd0, 3'd0);
    wr(A_CTRL, {1'b1, 1'b1, 1'b0, 5'd3});
    repeat (5) @(negedge clk);
    wr(A_CTRL, {1'b1, 1'b1, 1'b0, 5'd4});
    wr(6'h10, 8'h99);
    wait_idle(c);
    op(1'b0, 1'b0, 5'd4, c);
    chk(6'h00, 8'hFF, "R11 second start ignored");
    op(1'b0, 1'b0, 5'd3, c);
    chk(6'h00, 8'h55, "R11 first write done");
    chk(6'h10, 8'h55, "R11 buffer write ignored");

    wr(A_WPROT, 8'h02);
    op(1'b1, 1'b0, 5'd1, c);
    cmpi(c, 0, "R5 protected write no busy");
    chk(A_STAT, 8'h01, "R5 error set");
    op(1'b0, 1'b0, 5'd1, c);
    chk(6'h00, 8'hFF, "R5 protected row unchanged");
    chk(A_STAT, 8'h01, "R12 error sticky");
    wr(A_WPROT, 8'h00);
    chk(A_WPROT, 8'h02, "R8 wprot cannot clear");
    op(1'b1, 1'b0, 5'd0, c);
    cmpi(c, 98, "R5 unprotected row writable");
    wr(A_STAT, 8'h01);
    chk(A_STAT, 8'h00, "R12 error cleared");

    setcmd(1'b1, 2'd0, 3'd0);
    op(1'b1, 1'b0, 5'd0, c);
    cmpi(c, 0, "R9 zero count no busy");
    chk(A_STAT, 8'h01, "R9 zero count error");
    wr(A_STAT, 8'h01);

    wr(A_MODE, 8'h02);
    wait_idle(c);
    cmpi(c, 98, "R10 force max busy");
    setcmd(1'b0, 2'd2, 3'd0);
    op(1'b0, 1'b0, 5'd9, c);
    for (int i = 0; i < 4; i++) chk(6'(i), 8'h00, "R10 max stored inverted");

    setcmd(1'b1, 2'd0, 3'd0);
    op(1'b1, 1'b0, 5'd0, c);
    cmpi(c, 98, "R9 decrement busy");
    op(1'b1, 1'b0, 5'd0, c);
    setcmd(1'b0, 2'd2, 3'd0);
    op(1'b0, 1'b0, 5'd9, c);
    chk(6'h00, 8'h02, "R9 two decrements low byte");
    chk(6'h01, 8'h00, "R9 two decrements byte 1");
    chk(A_STAT, 8'h00, "R9 no error");

    wr(A_MODE, 8'h01);
    setcmd(1'b1, 2'd0, 3'd0);
    op(1'b1, 1'b0, 5'd0, c);
    cmpi(c, 0, "R10 stopped decrement no busy");
    setcmd(1'b0, 2'd2, 3'd0);
    op(1'b0, 1'b0, 5'd9, c);
    chk(6'h00, 8'h02, "R10 stopped count unchanged");
    chk(A_STAT, 8'h00, "R10 stop no error");
    wr(A_MODE, 8'h00);

    wr(A_SEC, 8'h04);
    setcmd(1'b1, 2'd0, 3'd0);
    op(1'b1, 1'b0, 5'd0, c);
    cmpi(c, 0, "R6 counter lock blocks decrement");
    chk(A_STAT, 8'h01, "R6 counter lock error");
    wr(A_STAT, 8'h01);
    wr(6'h10, 8'h77);
    setcmd(1'b0, 2'd0, 3'd1);
    op(1'b1, 1'b0, 5'd9, c);
    cmpi(c, 0, "R6 counter lock blocks direct write");
    chk(A_STAT, 8'h01, "R6 direct write error");
    wr(A_STAT, 8'h01);
    setcmd(1'b0, 2'd2, 3'd0);
    op(1'b0, 1'b0, 5'd9, c);
    chk(6'h00, 8'h02, "R6 counter intact");
    chk(6'h01, 8'h00, "R6 counter byte 1 intact");
    setcmd(1'b0, 2'd0, 3'd4);
    op(1'b1, 1'b0, 5'd9, c);
    cmpi(c, 98, "R6 byte beside counter writable");

    wr(A_SEC, 8'h01);
    setcmd(1'b0, 2'd0, 3'd0);
    op(1'b1, 1'b0, 5'd5, c);
    cmpi(c, 0, "R6 global write lock");
    chk(A_STAT, 8'h01, "R6 global lock error");
    wr(A_STAT, 8'h01);
    op(1'b0, 1'b0, 5'd5, c);
    chk(6'h00, 8'hFF, "R6 locked row unchanged");

    wr(A_SEC, 8'h02);
    chk(A_SEC, 8'h07, "R8 security accumulates");
    op(1'b0, 1'b0, 5'd2, c);
    cmpi(c, 0, "R7 protected read no busy");
    chk(6'h00, 8'hFF, "R7 read buffer unchanged");
    chk(A_STAT, 8'h01, "R7 read protect error");
    wr(A_SEC, 8'h00);
    chk(A_SEC, 8'h07, "R8 security cannot clear");

    summary();
  end
endmodule